// File: doc/BRIEF.md
# Multi-Domain Clock Divider with Software Gating

This block takes one input clock and produces a vector of output clocks. Each output is the input divided by an integer ratio that is fixed when the block is built. A ratio of one passes the input clock straight through. Every other ratio must be even, so each divided output is high for exactly half of its period.

Software controls the outputs through a small APB3 slave with a 12-bit address and 32-bit data. It can read an identification word, a version word and the number of outputs. It can also read and write a run mask with one bit per output. Clearing a bit holds that output low. The cut never produces a shortened pulse. The divider behind a held output keeps counting, so when the bit is set again the output returns in step with where it would have been.

Top module: `clkDivCtrl`

## Requirements
- R1: Each divide ratio must be 1 or an even integer. Any other value stops elaboration with an error. Every divided output is high for exactly ratio/2 input cycles in each period.
- R2: While reset is held, and at the first edge after it is released, every divided output is high. After release, each divided output toggles every ratio/2 rising edges of the input clock.
- R3: An output whose ratio is 1 follows the input clock (high while the input is high) whenever its run bit is set.
- R4: Offset 0x00C holds the run mask. Bit n belongs to output n. After reset the mask reads all ones in the low NUM_DOMAINS bits. A write stores pwdata[NUM_DOMAINS-1:0]. Bits at and above NUM_DOMAINS read as 0.
- R5: When run bit n is 0, output n is held low. A high pulse is never cut short, and the output resumes with a full high pulse once the bit is 1 again.
- R6: The dividers keep counting while their output is held, so an output that resumes is in the same phase as a divider that was never held.
- R7: Offset 0x008 reads NUM_DOMAINS in bits 7:0, with 0 in bits 31:8.
- R8: Offset 0x000 reads 0x000C in bits 31:16, 0x01 in bits 15:8 and 0 in bits 7:0. Offset 0x004 reads all zeros, because the minor version (bits 31:16) and the patch version (bits 15:0) are both 0.
- R9: Every transfer completes without wait states, and pslverr is always 0. Reads of any other offset return 0. Writes to any offset other than 0x00C leave the run mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkIn | input | 1 | Source clock |
| rstN | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when 1, read when 0 |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| pslverr | output | 1 | APB error, always 0 |
| clkOut | output | NUM_DOMAINS | Generated, gated clocks |

## Verification
The following properties are checked on every rising edge by assertions:
- the fixed words returned at the identification and count offsets;
- the run mask taking the written value after a write to 0x00C;
- the run mask staying unchanged after writes to any other offset;
- divided outputs being high when reset is released;
- a held output being low once its bit has been clear for longer than its ratio.

Only the bench scenarios can show the following:
- the exact half-period count of each divided output;
- phase continuity after a hold, compared against a count of edges since reset;
- the absence of short pulses across random mask changes;
- the pass-through of the ratio-one output, which needs samples in both halves of the input period.

// File: rtl/clkDivPkg.sv
package clkDivPkg;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_ID    = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_VER   = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_COUNT = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 12'h00C;

  localparam logic [15:0] ID_CODE    = 16'h000C;
  localparam logic [7:0]  VER_MAJOR  = 8'h01;
  localparam logic [15:0] VER_MINOR  = 16'h0000;
  localparam logic [15:0] VER_PATCH  = 16'h0000;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ID,
    SEL_VER,
    SEL_COUNT,
    SEL_MASK
  } regSel_e;

  // Strobes from bus decode to the clock datapath
  typedef struct packed {
    logic    maskWr;
    regSel_e rdSel;
  } busStrobe_t;

endpackage

// File: rtl/clkDivCell.sv
// One divider: toggles its output every HALF rising edges, starts high.
module clkDivCell #(
  parameter int unsigned HALF = 1
) (
  input  logic clkIn,
  input  logic rstN,
  output logic divClk
);

  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clkIn) begin
    if (!rstN) begin
      cnt    <= '0;
      divClk <= 1'b1;
    end else if (cnt == LAST) begin
      cnt    <= '0;
      divClk <= ~divClk;
    end else begin
      cnt    <= cnt + CW'(1);
    end
  end

endmodule

// File: rtl/clkGateCell.sv
// Glitch-free gate: enable captured only while the source clock is low.
module clkGateCell (
  input  logic rstN,
  input  logic srcClk,
  input  logic en,
  output logic gClk
);

  logic enLat;

  always_latch begin
    if (!rstN)        enLat <= 1'b1;
    else if (!srcClk) enLat <= en;
  end

  assign gClk = srcClk & enLat;

endmodule

// File: rtl/apbCtrl.sv
// Address decode for the APB slave; produces strobes for the datapath.
module apbCtrl
  import clkDivPkg::*;
(
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output busStrobe_t        strobe,
  output logic              pready,
  output logic              pslverr
);

  regSel_e hitSel;

  always_comb begin
    hitSel = SEL_NONE;
    if (psel) begin
      case (paddr)
        OFF_ID:    hitSel = SEL_ID;
        OFF_VER:   hitSel = SEL_VER;
        OFF_COUNT: hitSel = SEL_COUNT;
        OFF_MASK:  hitSel = SEL_MASK;
        default:   hitSel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    strobe.rdSel  = pwrite ? SEL_NONE : hitSel;
    strobe.maskWr = psel && penable && pwrite && (hitSel == SEL_MASK);
  end

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

endmodule

// File: rtl/clkDatapath.sv
// Run mask, dividers, gates and read-data mux.
module clkDatapath
  import clkDivPkg::*;
#(
  parameter int unsigned NUM_DOMAINS = 4,
  parameter int unsigned DIV_RATIO [NUM_DOMAINS] = '{32'd1, 32'd2, 32'd4, 32'd6}
) (
  input  logic                   clkIn,
  input  logic                   rstN,
  input  busStrobe_t             strobe,
  input  logic [DATA_W-1:0]      pwdata,
  output logic [DATA_W-1:0]      prdata,
  output logic [NUM_DOMAINS-1:0] runMask,
  output logic [NUM_DOMAINS-1:0] divClk,
  output logic [NUM_DOMAINS-1:0] clkOut
);

  logic unusedData;
  assign unusedData = ^pwdata;

  always_ff @(posedge clkIn) begin
    if (!rstN)              runMask <= '1;
    else if (strobe.maskWr) runMask <= pwdata[NUM_DOMAINS-1:0];
  end

  for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom
    if (DIV_RATIO[d] == 0 || (DIV_RATIO[d] != 1 && (DIV_RATIO[d] % 2) != 0)) begin : g_bad
      $error("clkDatapath: ratio of domain %0d must be 1 or even", d);
    end
    if (DIV_RATIO[d] == 1) begin : g_pass
      assign divClk[d] = clkIn;
    end else begin : g_div
      clkDivCell #(.HALF(DIV_RATIO[d] / 2)) u_div (
        .clkIn (clkIn),
        .rstN  (rstN),
        .divClk(divClk[d])
      );
    end
    clkGateCell u_gate (
      .rstN  (rstN),
      .srcClk(divClk[d]),
      .en    (runMask[d]),
      .gClk  (clkOut[d])
    );
  end

  always_comb begin
    case (strobe.rdSel)
      SEL_ID:    prdata = {ID_CODE, VER_MAJOR, 8'h00};
      SEL_VER:   prdata = {VER_MINOR, VER_PATCH};
      SEL_COUNT: prdata = DATA_W'(8'(NUM_DOMAINS));
      SEL_MASK:  prdata = DATA_W'(runMask);
      default:   prdata = '0;
    endcase
  end

endmodule

// File: rtl/clkDivCtrl.sv
module clkDivCtrl
  import clkDivPkg::*;
#(
  parameter int unsigned NUM_DOMAINS = 4,
  parameter int unsigned DIV_RATIO [NUM_DOMAINS] = '{32'd1, 32'd2, 32'd4, 32'd6}
) (
  input  logic                   clkIn,
  input  logic                   rstN,
  input  logic                   psel,
  input  logic                   penable,
  input  logic                   pwrite,
  input  logic [11:0]            paddr,
  input  logic [31:0]            pwdata,
  output logic [31:0]            prdata,
  output logic                   pready,
  output logic                   pslverr,
  output logic [NUM_DOMAINS-1:0] clkOut
);

  busStrobe_t             strobe;
  logic [NUM_DOMAINS-1:0] runMask;
  logic [NUM_DOMAINS-1:0] divClk;

  apbCtrl u_ctrl (
    .psel   (psel),
    .penable(penable),
    .pwrite (pwrite),
    .paddr  (paddr),
    .strobe (strobe),
    .pready (pready),
    .pslverr(pslverr)
  );

  clkDatapath #(
    .NUM_DOMAINS(NUM_DOMAINS),
    .DIV_RATIO  (DIV_RATIO)
  ) u_dp (
    .clkIn  (clkIn),
    .rstN   (rstN),
    .strobe (strobe),
    .pwdata (pwdata),
    .prdata (prdata),
    .runMask(runMask),
    .divClk (divClk),
    .clkOut (clkOut)
  );

endmodule

// File: rtl/clkDivCtrlChecker.sv
module clkDivCtrlChecker #(
  parameter int unsigned NUM_DOMAINS = 4,
  parameter int unsigned DIV_RATIO [NUM_DOMAINS] = '{32'd1, 32'd2, 32'd4, 32'd6}
) (
  input logic                   clkIn,
  input logic                   rstN,
  input logic                   psel,
  input logic                   penable,
  input logic                   pwrite,
  input logic [11:0]            paddr,
  input logic [31:0]            pwdata,
  input logic [31:0]            prdata,
  input logic [NUM_DOMAINS-1:0] runMask,
  input logic [NUM_DOMAINS-1:0] divClk,
  input logic [NUM_DOMAINS-1:0] clkOut
);

  logic unusedDiv;
  assign unusedDiv = ^divClk;

  logic rdAcc, wrAcc;
  assign rdAcc = psel && penable && !pwrite;
  assign wrAcc = psel && penable && pwrite;

  p_id_read_r8: assert property (@(posedge clkIn) disable iff (!rstN)
    (rdAcc && paddr == 12'h000) |-> prdata == 32'h000C_0100);

  p_count_read_r7: assert property (@(posedge clkIn) disable iff (!rstN)
    (rdAcc && paddr == 12'h008) |-> prdata == 32'(NUM_DOMAINS));

  p_mask_write_r4: assert property (@(posedge clkIn) disable iff (!rstN)
    (wrAcc && paddr == 12'h00C) |=> runMask == $past(pwdata[NUM_DOMAINS-1:0]));

  p_ro_ignore_r9: assert property (@(posedge clkIn) disable iff (!rstN)
    (wrAcc && paddr != 12'h00C) |=> $stable(runMask));

  for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_chk
    logic [7:0] heldCnt;
    always_ff @(posedge clkIn) begin
      if (!rstN || runMask[d]) heldCnt <= '0;
      else if (heldCnt != 8'hFF) heldCnt <= heldCnt + 8'd1;
    end

    p_gate_low_r5: assert property (@(posedge clkIn) disable iff (!rstN)
      (32'(heldCnt) > DIV_RATIO[d]) |-> !clkOut[d]);

    if (DIV_RATIO[d] > 1) begin : g_divchk
      p_start_high_r2: assert property (@(posedge clkIn) disable iff (!rstN)
        $rose(rstN) |-> divClk[d]);
    end
  end

endmodule

bind clkDivCtrl clkDivCtrlChecker #(
  .NUM_DOMAINS(NUM_DOMAINS),
  .DIV_RATIO  (DIV_RATIO)
) u_checker (
  .clkIn  (clkIn),
  .rstN   (rstN),
  .psel   (psel),
  .penable(penable),
  .pwrite (pwrite),
  .paddr  (paddr),
  .pwdata (pwdata),
  .prdata (prdata),
  .runMask(runMask),
  .divClk (divClk),
  .clkOut (clkOut)
);

// File: tb/clkDivCtrl_bench.sv
module clkDivCtrl_bench;

  localparam int unsigned ND = 4;
  localparam int unsigned RATIO [ND] = '{32'd1, 32'd2, 32'd4, 32'd6};

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0]   paddr = '0;
  logic [31:0]   pwdata = '0;
  logic [31:0]   prdata;
  logic          pready, pslverr;
  logic [ND-1:0] clkOut;

  int compared = 0;
  int mismatched = 0;
  int unsigned edgeCnt = 0;
  logic [ND-1:0] expMask = '1;
  bit monOn = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  clkDivCtrl #(.NUM_DOMAINS(ND), .DIV_RATIO(RATIO)) u_clkDivCtrl (
    .clkIn(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .clkOut(clkOut)
  );

  always @(posedge clk) if (rstN) edgeCnt++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic expDiv(input int d, input int unsigned k);
    return 1'b1 ^ 1'((k / (RATIO[d] / 2)) & 1);
  endfunction

  function automatic logic [31:0] expRead(input logic [11:0] a);
    case (a)
      12'h000: return 32'h000C_0100;
      12'h004: return 32'h0;
      12'h008: return 32'(ND);
      12'h00C: return 32'(expMask);
      default: return 32'h0;
    endcase
  endfunction

  task automatic apbWrite(input logic [11:0] a, input logic [31:0] dat);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = dat;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    if (a == 12'h00C) expMask = dat[ND-1:0];
  endtask

  task automatic apbRead(input logic [11:0] a, input string req);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1;
    check(req, prdata, expRead(a));
    check("R9 pready/pslverr", {30'b0, pready, pslverr}, 32'h2);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  // Compare outputs in both clock phases over a span of cycles (R2 R3 R5 R6)
  task automatic checkClocks(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(posedge clk); #1;
      for (int d = 0; d < int'(ND); d++) begin
        if (RATIO[d] == 1) check("R3 pass-through high phase", 32'(clkOut[d]), 32'(expMask[d]));
        else check("R6 divided phase (high)", 32'(clkOut[d]), 32'(expDiv(d, edgeCnt) & expMask[d]));
      end
      @(negedge clk); #1;
      for (int d = 0; d < int'(ND); d++) begin
        if (RATIO[d] == 1) check("R3 pass-through low phase", 32'(clkOut[d]), 32'h0);
        else check("R5 divided gated (low phase)", 32'(clkOut[d]), 32'(expDiv(d, edgeCnt) & expMask[d]));
      end
    end
  endtask

  // Pulse-width monitor: every complete high pulse lasts ratio/2 edges (R1 R5)
  int unsigned runLen [ND];
  logic        prevOut [ND];
  bit          armed [ND];
  initial begin
    for (int d = 0; d < int'(ND); d++) begin runLen[d] = 0; prevOut[d] = 1'b1; armed[d] = 1'b0; end
    forever begin
      @(posedge clk); #1;
      if (monOn) begin
        for (int d = 0; d < int'(ND); d++) begin
          if (RATIO[d] > 1) begin
            if (clkOut[d] == prevOut[d]) runLen[d]++;
            else begin
              if (armed[d] && prevOut[d] == 1'b1)
                check("R1 high pulse width", runLen[d], RATIO[d] / 2);
              armed[d] = 1'b1;
              runLen[d] = 1;
              prevOut[d] = clkOut[d];
            end
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C11));
    repeat (3) @(negedge clk);
    // R2: divided outputs high while reset is held
    for (int d = 0; d < int'(ND); d++)
      if (RATIO[d] > 1) check("R2 high during reset", 32'(clkOut[d]), 32'h1);
    rstN = 1'b1;
    monOn = 1'b1;
    checkClocks(14);

    apbRead(12'h000, "R8 id word");
    apbRead(12'h004, "R8 version word");
    apbRead(12'h008, "R7 domain count");
    apbRead(12'h00C, "R4 mask reset all ones");
    apbRead(12'h010, "R9 unmapped read zero");
    apbRead(12'hFFC, "R9 unmapped read zero");

    apbWrite(12'h008, 32'hFFFF_FFFF);
    apbRead(12'h008, "R9 count write ignored");
    apbWrite(12'h000, 32'h1234_5678);
    apbRead(12'h000, "R9 id write ignored");
    apbWrite(12'h020, 32'h0);
    apbRead(12'h00C, "R9 unmapped write leaves mask");

    apbWrite(12'h00C, 32'h0);
    repeat (8) @(posedge clk);
    checkClocks(12);
    apbWrite(12'h00C, 32'h5);
    repeat (8) @(posedge clk);
    checkClocks(12);
    apbWrite(12'h00C, 32'hFFFF_FFF0);
    apbRead(12'h00C, "R4 upper bits not stored");
    repeat (8) @(posedge clk);
    checkClocks(6);
    apbWrite(12'h00C, 32'hF);
    repeat (8) @(posedge clk);
    checkClocks(12);

    for (int it = 0; it < 60; it++) begin
      int unsigned op;
      op = $urandom % 4;
      if (op == 0 || op == 1) begin
        apbWrite(12'h00C, $urandom);
        repeat (8 + ($urandom % 9)) @(posedge clk);
        checkClocks(6 + int'($urandom % 7));
      end else if (op == 2) begin
        logic [11:0] a;
        a = ($urandom % 2 == 0) ? 12'(($urandom % 6) * 4) : 12'($urandom);
        apbRead(a, "R9 random read");
      end else begin
        logic [11:0] a;
        a = 12'($urandom);
        if (a == 12'h00C) a = 12'h00D;
        apbWrite(a, $urandom);
        apbRead(12'h00C, "R9 random write leaves mask");
      end
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule